// File: doc/BRIEF.md
# Pulse Amplitude Normalizer

This block accepts two signed sample streams taken on the same clock edge from a dual-channel converter. One channel carries the flat top of a pulse and the other carries the flat level between pulses. A new pulse arrives on every clock. The block subtracts the baseline sample from the peak sample to recover the true pulse height, which the AC-coupled inputs would otherwise lose. It then divides that height by the height of the pulse just before it. The result is an unsigned fixed-point ratio that cancels slow gain and offset drift in the optical and analog chain.

The division is a fully pipelined restoring divider with one stage per quotient bit, so the block accepts a sample on every clock. A valid bit travels with each result. Results that the format cannot hold, and divisions by a zero-height pulse, are pinned to the largest code. A divide by zero also raises an error flag. With the default parameters the ratio has 2 integer bits and 14 fraction bits.

Top module: `pulseNormalizer`

## Requirements
- R1: While `rstN` is low, and on the first clock after it, `outValid` is 0, `ratioOut` is 0 and `divErr` is 0. Results still in flight when reset is applied never appear at the outputs.
- R2: For a valid sample with peak P and baseline B, read as 16-bit two's complement, the height is A = P - B. The result is floor(A * 16384 / Aprev), an unsigned value in which bit 14 weighs 1.0. Aprev is the height of the previous valid sample.
- R3: When P - B is negative, the height is taken as 0, both as the dividend and as the next history value.
- R4: A valid sample whose previous cycle had `inValid` low, or that is the first valid sample after reset, produces no result. It only loads the history.
- R5: The result for a sample captured at rising edge t is presented after edge t+16, and a new sample can be captured on every edge.
- R6: When the quotient would be 65536 or more (A >= 4 * Aprev with Aprev nonzero), `ratioOut` is 16'hFFFF and `divErr` is 0.
- R7: When Aprev is 0, `ratioOut` is 16'hFFFF and `divErr` is 1.
- R8: Whenever `outValid` is 0, `ratioOut` and `divErr` are both 0.
- R9: Every valid sample updates the history, including samples whose own result saturated, flagged an error or was suppressed under R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one pulse per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Peak and baseline inputs hold a pulse this cycle |
| peakIn | input | 16 | Signed sample taken on the pulse top |
| baseIn | input | 16 | Signed sample taken on the baseline |
| outValid | output | 1 | A normalized result is present |
| ratioOut | output | 16 | Unsigned ratio, 2 integer and 14 fraction bits |
| divErr | output | 1 | The previous pulse height was zero |

## Verification
The hardest case to reach is a zero-height history. It needs a pulse whose baseline sits above its peak, followed at once by another valid pulse without a gap, so that the clamped zero is used as the divisor and not discarded by a gap restart. The stimulus builds this case directly. It also places exact boundaries next to each other: a height of precisely four times the previous one (saturates), one just below it (largest unsaturated code), and a full-scale 65535 height divided by 16384 (yields 65535 without saturation). A behavioural model with a result queue is compared against the outputs on every clock through pseudo-random runs with gaps, and through a reset issued while the pipeline is full.

// File: rtl/pulseNormPkg.sv
package pulseNormPkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic loadHist;   // capture this cycle's height as history
    logic launch;     // start a division in the pipeline
  } normCtrl_t;

endpackage

// File: rtl/normControl.sv
module normControl
  import pulseNormPkg::*;
#(
  parameter int LAT_STAGES = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output normCtrl_t ctrlS,
  output logic      outValid
);

  logic                  primed;
  logic [LAT_STAGES:0]   validPipe;

  always_comb begin
    ctrlS.loadHist = inValid;
    ctrlS.launch   = inValid && primed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed    <= 1'b0;
      validPipe <= '0;
    end else begin
      primed    <= inValid;   // a gap drops the history
      validPipe <= {validPipe[LAT_STAGES-1:0], ctrlS.launch};
    end
  end

  assign outValid = validPipe[LAT_STAGES];

endmodule

// File: rtl/divStage.sv
module divStage #(
  parameter int DATA_W = 16,
  parameter int Q_W    = 16
) (
  input  logic              clk,
  input  logic [DATA_W-1:0] remIn,
  input  logic [Q_W-1:0]    nLowIn,
  input  logic [Q_W-1:0]    quoIn,
  input  logic [DATA_W-1:0] divIn,
  input  logic              satIn,
  input  logic              zeroIn,
  output logic [DATA_W-1:0] remOut,
  output logic [Q_W-1:0]    nLowOut,
  output logic [Q_W-1:0]    quoOut,
  output logic [DATA_W-1:0] divOut,
  output logic              satOut,
  output logic              zeroOut
);

  logic [DATA_W:0]   remShift;
  logic              fits;
  logic [DATA_W-1:0] remNext;

  always_comb begin
    remShift = {remIn, nLowIn[Q_W-1]};
    fits     = remShift >= {1'b0, divIn};
    remNext  = fits ? DATA_W'(remShift - {1'b0, divIn}) : remShift[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    remOut  <= remNext;
    nLowOut <= {nLowIn[Q_W-2:0], 1'b0};
    quoOut  <= {quoIn[Q_W-2:0], fits};
    divOut  <= divIn;
    satOut  <= satIn;
    zeroOut <= zeroIn;
  end

endmodule

// File: rtl/normDatapath.sv
module normDatapath
  import pulseNormPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 14
) (
  input  logic              clk,
  input  normCtrl_t         ctrlS,
  input  logic [DATA_W-1:0] peakIn,
  input  logic [DATA_W-1:0] baseIn,
  output logic [DATA_W-1:0] ratioRaw,
  output logic              errRaw
);

  localparam int SHIFT = DATA_W - FRAC_W;   // integer bits of the ratio, at least 1
  localparam int Q_W   = DATA_W;
  localparam int NUM_W = DATA_W + FRAC_W;

  logic [DATA_W:0]     diff;
  logic [DATA_W-1:0]   amp;
  logic [DATA_W-1:0]   histAmp;
  logic [NUM_W-1:0]    numer;
  logic                zeroDiv;
  logic                satDiv;

  logic [DATA_W-1:0] remS  [0:Q_W];
  logic [Q_W-1:0]    nLowS [0:Q_W];
  logic [Q_W-1:0]    quoS  [0:Q_W];
  logic [DATA_W-1:0] divS  [0:Q_W];
  logic              satS  [0:Q_W];
  logic              zeroS [0:Q_W];

  always_comb begin
    diff    = {peakIn[DATA_W-1], peakIn} - {baseIn[DATA_W-1], baseIn};
    amp     = diff[DATA_W] ? '0 : diff[DATA_W-1:0];
    numer   = {amp, {FRAC_W{1'b0}}};
    zeroDiv = (histAmp == '0);
    satDiv  = !zeroDiv &&
              ({{SHIFT{1'b0}}, amp} >= {histAmp, {SHIFT{1'b0}}});
  end

  always_ff @(posedge clk) begin
    if (ctrlS.loadHist) histAmp <= amp;
    if (ctrlS.launch) begin
      remS[0]  <= {{SHIFT{1'b0}}, numer[NUM_W-1:Q_W]};
      nLowS[0] <= numer[Q_W-1:0];
      quoS[0]  <= '0;
      divS[0]  <= histAmp;
      satS[0]  <= satDiv;
      zeroS[0] <= zeroDiv;
    end
  end

  for (genvar g = 0; g < Q_W; g++) begin : gStage
    divStage #(.DATA_W(DATA_W), .Q_W(Q_W)) u_stage (
      .clk    (clk),
      .remIn  (remS[g]),
      .nLowIn (nLowS[g]),
      .quoIn  (quoS[g]),
      .divIn  (divS[g]),
      .satIn  (satS[g]),
      .zeroIn (zeroS[g]),
      .remOut (remS[g+1]),
      .nLowOut(nLowS[g+1]),
      .quoOut (quoS[g+1]),
      .divOut (divS[g+1]),
      .satOut (satS[g+1]),
      .zeroOut(zeroS[g+1])
    );
  end

  assign ratioRaw = (satS[Q_W] || zeroS[Q_W]) ? '1 : quoS[Q_W];
  assign errRaw   = zeroS[Q_W];

endmodule

// File: rtl/pulseNormalizer.sv
module pulseNormalizer
  import pulseNormPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] peakIn,
  input  logic [DATA_W-1:0] baseIn,
  output logic              outValid,
  output logic [DATA_W-1:0] ratioOut,
  output logic              divErr
);

  normCtrl_t         ctrlS;
  logic              pipeValid;
  logic [DATA_W-1:0] ratioRaw;
  logic              errRaw;

  normControl #(.LAT_STAGES(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .ctrlS   (ctrlS),
    .outValid(pipeValid)
  );

  normDatapath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_dp (
    .clk     (clk),
    .ctrlS   (ctrlS),
    .peakIn  (peakIn),
    .baseIn  (baseIn),
    .ratioRaw(ratioRaw),
    .errRaw  (errRaw)
  );

  assign outValid = pipeValid;
  assign ratioOut = pipeValid ? ratioRaw : '0;
  assign divErr   = pipeValid && errRaw;

endmodule

// File: rtl/pulseNormalizer_chk.sv
module pulseNormalizer_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              outValid,
  input logic [DATA_W-1:0] ratioOut,
  input logic              divErr,
  input logic              launch
);

  // Independent prediction of which cycles carry a result.
  logic              primedChk;
  logic [DATA_W:0]   expValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primedChk <= 1'b0;
      expValid  <= '0;
    end else begin
      primedChk <= inValid;
      expValid  <= {expValid[DATA_W-1:0], inValid && primedChk};
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rstN |=> !outValid);

  p_first_no_launch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !primedChk) |-> !launch);

  p_valid_timing_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid == expValid[DATA_W]);

  p_err_saturates_r7: assert property (@(posedge clk) disable iff (!rstN)
    divErr |-> (&ratioOut));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (ratioOut == '0 && !divErr));

endmodule

bind pulseNormalizer pulseNormalizer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .outValid(outValid),
  .ratioOut(ratioOut),
  .divErr  (divErr),
  .launch  (ctrlS.launch)
);

// File: tb/pulseNormalizer_tb.sv
`timescale 1ns/1ps
module pulseNormalizer_tb;

  localparam int LAT = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] peakIn = '0;
  logic [15:0] baseIn = '0;
  logic        outValid;
  logic [15:0] ratioOut;
  logic        divErr;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit    v;
    int    ratio;
    bit    err;
    string tag;
  } exp_t;

  exp_t q[$];
  int   prevAmp = 0;
  bit   primed = 1'b0;
  bit   prevSpecial = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  pulseNormalizer u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .peakIn(peakIn), .baseIn(baseIn),
    .outValid(outValid), .ratioOut(ratioOut), .divErr(divErr)
  );

  task automatic compareOut(input exp_t e);
    checks++;
    if (outValid !== e.v || ratioOut !== e.ratio[15:0] || divErr !== e.err) begin
      errors++;
      $display("FAIL %s: got v=%0b ratio=%0d err=%0b expected v=%0b ratio=%0d err=%0b",
               e.tag, outValid, ratioOut, divErr, e.v, e.ratio, e.err);
    end
  endtask

  task automatic checkQuiet(input string tag);
    exp_t e;
    e.v = 0; e.ratio = 0; e.err = 0; e.tag = tag;
    compareOut(e);
  endtask

  // One clock of stimulus; the model result enters the queue.
  task automatic step(input bit v, input int p, input int b);
    exp_t e;
    int   amp;
    longint quo;
    @(negedge clk);
    if (q.size() == LAT + 1) compareOut(q.pop_front());   // R5 timing
    inValid = v;
    peakIn  = p[15:0];
    baseIn  = b[15:0];
    e.v = 0; e.ratio = 0; e.err = 0; e.tag = "R8 idle";
    if (v) begin
      amp = p - b;
      if (amp < 0) amp = 0;                               // R3 clamp
      if (!primed) e.tag = "R4 first after gap";
      else begin
        e.v = 1;
        if (prevAmp == 0) begin
          e.ratio = 65535; e.err = 1; e.tag = "R7 zero divisor";
        end else begin
          quo = (longint'(amp) * 16384) / prevAmp;
          if (quo > 65535) begin e.ratio = 65535; e.tag = "R6 saturate"; end
          else begin
            e.ratio = int'(quo);
            e.tag = (p - b < 0) ? "R3 clamped" : (prevSpecial ? "R9 history" : "R2 ratio");
          end
        end
      end
      prevSpecial = (e.v && (e.err || e.ratio == 65535)) || !primed || (p - b < 0);
      prevAmp = amp;                                      // R9 always loads
      primed  = 1;
    end else begin
      primed = 0;
    end
    q.push_back(e);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 0; inValid = 0;
    repeat (3) begin
      @(negedge clk);
      checkQuiet("R1 reset");
    end
    rstN = 1;
    q.delete();
    primed = 0; prevAmp = 0; prevSpecial = 0;
    @(negedge clk);
    checkQuiet("R1 after reset");
  endtask

  initial begin
    #(20.0 * 200000);
    errors++;
    $display("FAIL watchdog: got running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    applyReset();

    // R2: steady pulses give unity
    for (int i = 0; i < 20; i++) step(1, 8000, -2000);
    // R2: slowly varying heights
    for (int i = 0; i < 40; i++) step(1, 4000 + i * 37, -1000 + i * 5);

    // R3 then R7: negative difference becomes a zero divisor
    step(1, -100, 300);
    step(1, 2000, 100);
    step(1, 2100, 100);

    // R6 boundary: exactly 4.0 saturates, just below does not
    step(1, 100, 0);
    step(1, 400, 0);
    step(1, 100, 0);
    step(1, 399, 0);
    // R2 full scale: 65535 / 16384 gives 65535 without saturation
    step(1, 16384, 0);
    step(1, 32767, -32768);
    step(1, 1, 0);
    step(1, 0, 0);
    step(1, 5, 0);

    // R4: gaps restart the history
    step(1, 500, 0);
    step(0, 9999, 0);
    step(1, 1000, 0);
    step(1, 2000, 0);
    step(0, 0, 0);
    step(0, 0, 0);
    step(1, 700, 0);
    step(1, 350, 0);

    // Pseudo-random 14-bit samples widened to 16 bits, with gaps
    for (int i = 0; i < 400; i++) begin
      int pk, bs;
      pk = int'($urandom_range(0, 8191)) * 4;
      bs = -int'($urandom_range(0, 4095)) * 4;
      if ((i % 23) == 5) pk = bs - 8;    // clamp case
      step(($urandom_range(0, 7) != 0), pk, bs);
    end

    // R1: reset with a full pipeline flushes it
    for (int i = 0; i < 10; i++) step(1, 3000 + i * 100, 0);
    applyReset();
    for (int i = 0; i < 30; i++) step(1, 6000 - i * 50, -200);

    for (int i = 0; i < LAT + 2; i++) step(0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule